// File: doc/BRIEF.md
# Instruction Class Decoder with Condition Gate

This block takes one 32-bit instruction word and the four status flags (negative, zero, carry, overflow). It returns three things within the same cycle. The first is a one-hot class telling an execution stage which kind of operation the word encodes. The second is a small attribute vector that carries the control bits belonging to that class. The third is an execute enable taken from the 4-bit condition field. The block holds no state. A fetch or issue stage places it between the instruction register and the dispatch logic.

The class is found from a 12-bit key. Instruction bits 27:20 form the key's upper eight bits and instruction bits 7:4 form its lower four bits. Key bits 11:10 select one of three regions:

- **Arithmetic region** (`00`): a fixed chain of masked compares picks the class. The first compare that matches wins.
- **Memory region** (`01`): the word is a single load/store, or it is undefined.
- **Control region** (`1x`): the word is a block transfer, a branch, a trap, or undefined.

The condition code picks one of sixteen 16-bit truth masks. The mask bit addressed by {N,Z,C,V} decides whether the instruction may execute.

The named decode paths are:

- **Arithmetic region:** branch-exchange, multiply, swap, long multiply, halfword transfer, status transfer, data processing.
- **Memory region:** single transfer, undefined.
- **Control region:** block transfer, branch, trap, undefined.

The block has no sequential state and no transitions.

Top module: `insn_class_decoder`

## Requirements
- R1: class_o is always exactly one-hot. Bit positions: 0 data processing, 1 status transfer, 2 multiply, 3 long multiply, 4 swap, 5 branch-exchange, 6 halfword transfer, 7 single transfer, 8 block transfer, 9 branch, 10 trap, 11 undefined. The key is {instr[27:20], instr[7:4]}.
- R2: In the arithmetic region, the compares are tested in this order:
  1. key == 0x121 gives branch-exchange.
  2. (key & 0xFCF) == 0x009 gives multiply.
  3. (key & 0xFBF) == 0x109 gives swap.
  4. (key & 0xF8F) == 0x089 gives long multiply.

  An earlier match overrides any later one, including the compares listed in R3.
- R3: Next in the arithmetic region, (key & 0xE49) equal to 0x009 or 0x049 gives halfword transfer. Failing that, (key & 0xD90) == 0x100 gives status transfer. Anything else is data processing, with attr_o = {imm=key[9], op=key[8:5], setflags=key[4]}, imm in the most significant bit.
- R4: In the memory region, the word is undefined when key[9] and key[0] are both 1. Otherwise it is a single transfer with attr_o = key[9:4] (imm, pre, up, byte, writeback, load from bit 5 down to bit 0).
- R5: In the control region, key[10:9] selects the class:
  - 00 is block transfer, with attr_o[4:0] = key[8:4].
  - 01 is branch, with attr_o[0] = link = key[8].
  - 10 is undefined.
  - 11 is trap when key[8] is 1, and undefined otherwise.
- R6: Attribute layout for the arithmetic classes, with all higher bits 0:
  - Multiply: attr_o = {accumulate=key[5], setflags=key[4]}.
  - Long multiply: attr_o = {unsigned=key[6], key[5], key[4]}.
  - Swap: attr_o[0] = byte = key[6].
  - Halfword: attr_o[4:0] = key[8:4].
  - Status transfer: attr_o[3:0] = {key[9], key[6], key[5:4]}.
- R7: exec_o follows instr[31:28] with nzcv_i = {N,Z,C,V}:
  - EQ: Z. NE: !Z.
  - CS: C. CC: !C.
  - MI: N. PL: !N.
  - VS: V. VC: !V.
  - HI: C&!Z. LS: !C|Z.
  - GE: N==V. LT: N!=V.
  - GT: !Z&(N==V). LE: Z|(N!=V).
  - AL: always 1. NV: always 0.
- R8: When the condition fails, class_o and attr_o still show the decoded class. undef_o is 1 only when the class is undefined and exec_o is 1.
- R9: attr_o is 0 for branch-exchange, trap and undefined. Attribute bits above a class's field width are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| nzcv_i | input | 4 | Status flags {N,Z,C,V} |
| class_o | output | 12 | One-hot instruction class |
| attr_o | output | 6 | Class-specific control bits, right-aligned |
| undef_o | output | 1 | Undefined instruction that passed its condition |
| exec_o | output | 1 | Condition passed; instruction may execute |

## Verification
The decoder is purely combinational, so any fault in the region select, the priority chain or the mask table shows at the ports within the same evaluation. A fault in the priority chain shows on the overlapping keys. For example, key 0x121 also satisfies the status-transfer compare, and 0x009 and 0x109 also satisfy the halfword compare, so a misordered compare shows up as the wrong one-hot bit. A fault in the mask table shows as a single wrong exec_o value for a single condition and flag pair. The full 16×16 sweep therefore exposes any bit that is wrong.

// File: rtl/icd_pkg.sv
package icd_pkg;
    localparam int INSN_W   = 32;
    localparam int KEY_W    = 12;
    localparam int NCLASS   = 12;
    localparam int ATTR_W   = 6;
    localparam int FLAG_W   = 4;
    localparam int COND_W   = 4;
    localparam int NCOND    = 1 << COND_W;
    localparam int NFLAGCMB = 1 << FLAG_W;

    localparam int C_DP   = 0;
    localparam int C_PSR  = 1;
    localparam int C_MUL  = 2;
    localparam int C_MULL = 3;
    localparam int C_SWP  = 4;
    localparam int C_BX   = 5;
    localparam int C_HALF = 6;
    localparam int C_SDT  = 7;
    localparam int C_BLK  = 8;
    localparam int C_BR   = 9;
    localparam int C_TRAP = 10;
    localparam int C_UND  = 11;

    typedef enum logic [1:0] {
        RG_ARITH = 2'b00,
        RG_MEM   = 2'b01,
        RG_CTL_A = 2'b10,
        RG_CTL_B = 2'b11
    } region_e;

    function automatic logic [NCLASS-1:0] onehot_cls(input int pos);
        logic [NCLASS-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    // Truth mask per condition code, bit index = {N,Z,C,V}
    function automatic logic [NFLAGCMB-1:0] cond_mask(input logic [COND_W-1:0] c);
        logic [NFLAGCMB-1:0] m;
        case (c)
            4'h0: m = 16'hF0F0;
            4'h1: m = 16'h0F0F;
            4'h2: m = 16'hCCCC;
            4'h3: m = 16'h3333;
            4'h4: m = 16'hFF00;
            4'h5: m = 16'h00FF;
            4'h6: m = 16'hAAAA;
            4'h7: m = 16'h5555;
            4'h8: m = 16'h0C0C;
            4'h9: m = 16'hF3F3;
            4'hA: m = 16'hAA55;
            4'hB: m = 16'h55AA;
            4'hC: m = 16'h0A05;
            4'hD: m = 16'hF5FA;
            4'hE: m = 16'hFFFF;
            default: m = 16'h0000;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/icd_arith_dec.sv
module icd_arith_dec
    import icd_pkg::*;
(
    input  logic [KEY_W-1:0]  key_i,
    output logic [NCLASS-1:0] cls_o,
    output logic [ATTR_W-1:0] attr_o
);
    localparam logic [KEY_W-1:0] K_BX      = 12'h121;
    localparam logic [KEY_W-1:0] M_MUL     = 12'hFCF;
    localparam logic [KEY_W-1:0] V_MUL     = 12'h009;
    localparam logic [KEY_W-1:0] M_SWP     = 12'hFBF;
    localparam logic [KEY_W-1:0] V_SWP     = 12'h109;
    localparam logic [KEY_W-1:0] M_MULL    = 12'hF8F;
    localparam logic [KEY_W-1:0] V_MULL    = 12'h089;
    localparam logic [KEY_W-1:0] M_HALF    = 12'hE49;
    localparam logic [KEY_W-1:0] V_HALF_R  = 12'h009;
    localparam logic [KEY_W-1:0] V_HALF_I  = 12'h049;
    localparam logic [KEY_W-1:0] M_PSR     = 12'hD90;
    localparam logic [KEY_W-1:0] V_PSR     = 12'h100;

    logic hit_bx, hit_mul, hit_swp, hit_mull, hit_half, hit_psr;

    always_comb begin
        hit_bx   = (key_i == K_BX);
        hit_mul  = ((key_i & M_MUL) == V_MUL);
        hit_swp  = ((key_i & M_SWP) == V_SWP);
        hit_mull = ((key_i & M_MULL) == V_MULL);
        hit_half = ((key_i & M_HALF) == V_HALF_R) || ((key_i & M_HALF) == V_HALF_I);
        hit_psr  = ((key_i & M_PSR) == V_PSR);
    end

    always_comb begin
        cls_o  = '0;
        attr_o = '0;
        if (hit_bx) begin
            cls_o = onehot_cls(C_BX);
        end else if (hit_mul) begin
            cls_o  = onehot_cls(C_MUL);
            attr_o = {4'b0, key_i[5], key_i[4]};
        end else if (hit_swp) begin
            cls_o  = onehot_cls(C_SWP);
            attr_o = {5'b0, key_i[6]};
        end else if (hit_mull) begin
            cls_o  = onehot_cls(C_MULL);
            attr_o = {3'b0, key_i[6:4]};
        end else if (hit_half) begin
            cls_o  = onehot_cls(C_HALF);
            attr_o = {1'b0, key_i[8:4]};
        end else if (hit_psr) begin
            cls_o  = onehot_cls(C_PSR);
            attr_o = {2'b0, key_i[9], key_i[6], key_i[5:4]};
        end else begin
            cls_o  = onehot_cls(C_DP);
            attr_o = key_i[9:4];
        end
    end

    // Priority guards: an earlier compare must win over later overlapping ones
    always_comb begin
        if (!$isunknown(key_i)) begin
            if (hit_bx && hit_psr)
                a_r2_bx_over_psr: assert (cls_o[C_BX] && !cls_o[C_PSR]);
            if (hit_mul && hit_half)
                a_r2_mul_over_half: assert (cls_o[C_MUL] && !cls_o[C_HALF]);
            if (hit_swp && hit_half)
                a_r2_swp_over_half: assert (cls_o[C_SWP] && !cls_o[C_HALF]);
            if (cls_o[C_DP])
                a_r3_dp_only_fallback: assert (!hit_psr && !hit_half);
        end
    end
endmodule

// File: rtl/icd_mem_dec.sv
module icd_mem_dec
    import icd_pkg::*;
(
    input  logic [KEY_W-1:0]  key_i,
    output logic [NCLASS-1:0] cls_o,
    output logic [ATTR_W-1:0] attr_o
);
    logic reg_off_hole;

    always_comb begin
        reg_off_hole = key_i[9] & key_i[0];
        if (reg_off_hole) begin
            cls_o  = onehot_cls(C_UND);
            attr_o = '0;
        end else begin
            cls_o  = onehot_cls(C_SDT);
            attr_o = key_i[9:4];
        end
    end

    always_comb begin
        if (!$isunknown(key_i) && cls_o[C_UND])
            a_r4_hole_bits: assert (key_i[9] && key_i[0] && attr_o == '0);
    end
endmodule

// File: rtl/icd_ctl_dec.sv
module icd_ctl_dec
    import icd_pkg::*;
(
    input  logic [KEY_W-1:0]  key_i,
    output logic [NCLASS-1:0] cls_o,
    output logic [ATTR_W-1:0] attr_o
);
    always_comb begin
        cls_o  = onehot_cls(C_UND);
        attr_o = '0;
        unique case (key_i[10:9])
            2'b00: begin
                cls_o  = onehot_cls(C_BLK);
                attr_o = {1'b0, key_i[8:4]};
            end
            2'b01: begin
                cls_o  = onehot_cls(C_BR);
                attr_o = {5'b0, key_i[8]};
            end
            2'b10: begin
                cls_o  = onehot_cls(C_UND);
            end
            2'b11: begin
                cls_o = key_i[8] ? onehot_cls(C_TRAP) : onehot_cls(C_UND);
            end
            default: cls_o = onehot_cls(C_UND);
        endcase
    end

    always_comb begin
        if (!$isunknown(key_i) && cls_o[C_TRAP])
            a_r5_trap_key: assert (key_i[10:8] == 3'b111);
    end
endmodule

// File: rtl/icd_cond_eval.sv
module icd_cond_eval
    import icd_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLAG_W-1:0] nzcv_i,
    output logic              pass_o
);
    logic [NCOND-1:0] pass_vec;

    for (genvar c = 0; c < NCOND; c++) begin : g_cond
        localparam logic [NFLAGCMB-1:0] MASK = cond_mask(COND_W'(c));
        assign pass_vec[c] = MASK[nzcv_i];
    end

    assign pass_o = pass_vec[cond_i];

    always_comb begin
        if (!$isunknown({cond_i, nzcv_i})) begin
            if (cond_i == 4'hE) a_r7_always: assert (pass_o);
            if (cond_i == 4'hF) a_r7_never:  assert (!pass_o);
            if (cond_i == 4'h0) a_r7_eq_zero: assert (pass_o == nzcv_i[2]);
        end
    end
endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
    import icd_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [3:0]  nzcv_i,
    output logic [11:0] class_o,
    output logic [5:0]  attr_o,
    output logic        undef_o,
    output logic        exec_o
);
    logic [KEY_W-1:0]  key;
    logic [NCLASS-1:0] cls_ar, cls_mem, cls_ctl;
    logic [ATTR_W-1:0] attr_ar, attr_mem, attr_ctl;
    logic              cond_pass;
    region_e           region;

    assign key    = {instr_i[27:20], instr_i[7:4]};
    assign region = region_e'(key[11:10]);

    icd_arith_dec u_arith (.key_i(key), .cls_o(cls_ar),  .attr_o(attr_ar));
    icd_mem_dec   u_mem   (.key_i(key), .cls_o(cls_mem), .attr_o(attr_mem));
    icd_ctl_dec   u_ctl   (.key_i(key), .cls_o(cls_ctl), .attr_o(attr_ctl));

    icd_cond_eval u_cond (
        .cond_i (instr_i[31:28]),
        .nzcv_i (nzcv_i),
        .pass_o (cond_pass)
    );

    always_comb begin
        unique case (region)
            RG_ARITH: begin
                class_o = cls_ar;
                attr_o  = attr_ar;
            end
            RG_MEM: begin
                class_o = cls_mem;
                attr_o  = attr_mem;
            end
            RG_CTL_A, RG_CTL_B: begin
                class_o = cls_ctl;
                attr_o  = attr_ctl;
            end
            default: begin
                class_o = onehot_cls(C_UND);
                attr_o  = '0;
            end
        endcase
        exec_o  = cond_pass;
        undef_o = class_o[C_UND] & cond_pass;
    end

    always_comb begin
        if (!$isunknown({instr_i, nzcv_i})) begin
            a_r1_onehot:      assert ($onehot(class_o));
            if (undef_o)
                a_r8_undef_gated: assert (exec_o && class_o[C_UND]);
            if (class_o[C_BX] || class_o[C_TRAP] || class_o[C_UND])
                a_r9_attr_empty:  assert (attr_o == '0);
            if (class_o[C_BR])
                a_r9_br_narrow:   assert (attr_o[5:1] == '0);
        end
    end
endmodule

// File: tb/tb_insn_class_decoder.sv
module tb_insn_class_decoder;
    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [3:0]  nzcv;
    logic [11:0] class_o;
    logic [5:0]  attr_o;
    logic        undef_o, exec_o;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    insn_class_decoder dut (
        .instr_i(instr), .nzcv_i(nzcv), .class_o(class_o),
        .attr_o(attr_o), .undef_o(undef_o), .exec_o(exec_o)
    );

    localparam int DP = 0, PSR = 1, MUL = 2, MULL = 3, SWP = 4, BX = 5,
                   HALF = 6, SDT = 7, BLK = 8, BR = 9, TRAP = 10, UND = 11;

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [7:0] hi,
                                       input logic [3:0] lo);
        return {c, hi, 12'h000, lo, 4'h0};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [3:0] f);
        @(negedge clk);
        instr = w;
        nzcv  = f;
        #1;
    endtask

    task automatic chk_cls(input string req, input int cls, input logic [5:0] at);
        logic [11:0] exp_c;
        exp_c = 12'd1 << cls;
        total++;
        if (class_o !== exp_c || attr_o !== at) begin
            bad++;
            $display("FAIL %s instr=%h class=%h/%h attr=%b/%b (act/exp)",
                     req, instr, class_o, exp_c, attr_o, at);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s instr=%h nzcv=%b act=%b exp=%b", req, instr, nzcv, act, exp);
        end
    endtask

    task automatic t_reset_state;
        apply(32'hE000_0000, 4'h0);
        chk_cls("R1 idle word", DP, 6'b0);
        chk_bit("R1 idle exec", exec_o, 1'b1);
        chk_bit("R8 idle undef", undef_o, 1'b0);
    endtask

    task automatic t_r2_priority;
        apply(32'hE12F_FF11, 4'h0); chk_cls("R2 bx over psr", BX, 6'b0);
        apply(mk(4'hE, 8'h00, 4'h9), 4'h0); chk_cls("R2 mul over half", MUL, 6'b0);
        apply(mk(4'hE, 8'h03, 4'h9), 4'h0); chk_cls("R6 mul acc+s", MUL, 6'b000011);
        apply(mk(4'hE, 8'h10, 4'h9), 4'h0); chk_cls("R2 swp over half", SWP, 6'b0);
        apply(mk(4'hE, 8'h14, 4'h9), 4'h0); chk_cls("R6 swp byte", SWP, 6'b000001);
        apply(mk(4'hE, 8'h08, 4'h9), 4'h0); chk_cls("R2 mull over half", MULL, 6'b0);
        apply(mk(4'hE, 8'h0E, 4'h9), 4'h0); chk_cls("R6 mull u,a", MULL, 6'b000110);
    endtask

    task automatic t_r3_fallthrough;
        apply(mk(4'hE, 8'h1D, 4'hB), 4'h0); chk_cls("R3 half", HALF, 6'b011101);
        apply(mk(4'hE, 8'h10, 4'h0), 4'h0); chk_cls("R3 psr plain", PSR, 6'b0);
        apply(mk(4'hE, 8'h32, 4'h0), 4'h0); chk_cls("R6 psr imm", PSR, 6'b001010);
        apply(mk(4'hE, 8'h29, 4'h0), 4'h0); chk_cls("R3 dp adds imm", DP, 6'b101001);
        apply(mk(4'hE, 8'h1A, 4'h0), 4'h0); chk_cls("R3 dp mov", DP, 6'b011010);
    endtask

    task automatic t_r4_memory;
        apply(mk(4'hE, 8'h59, 4'h0), 4'h0); chk_cls("R4 sdt imm", SDT, 6'b011001);
        apply(mk(4'hE, 8'h79, 4'h0), 4'h0); chk_cls("R4 sdt reg", SDT, 6'b111001);
        apply(mk(4'hE, 8'h7F, 4'hF), 4'h0); chk_cls("R4 hole", UND, 6'b0);
        chk_bit("R8 hole undef", undef_o, 1'b1);
        apply(mk(4'hE, 8'h5F, 4'hF), 4'h0); chk_cls("R4 imm no hole", SDT, 6'b011111);
    endtask

    task automatic t_r5_control;
        apply(mk(4'hE, 8'h8B, 4'h0), 4'h0); chk_cls("R5 block", BLK, 6'b001011);
        apply(mk(4'hE, 8'hB0, 4'h0), 4'h0); chk_cls("R5 branch link", BR, 6'b000001);
        apply(mk(4'hE, 8'hA0, 4'h0), 4'h0); chk_cls("R5 branch", BR, 6'b0);
        apply(mk(4'hE, 8'hC0, 4'h0), 4'h0); chk_cls("R5 undef 10", UND, 6'b0);
        apply(mk(4'hE, 8'hF0, 4'h0), 4'h0); chk_cls("R5 trap", TRAP, 6'b0);
        apply(mk(4'hE, 8'hE0, 4'h0), 4'h0); chk_cls("R5 undef 11", UND, 6'b0);
    endtask

    function automatic logic exp_cond(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;          4'h1: return !z;
            4'h2: return cy;         4'h3: return !cy;
            4'h4: return n;          4'h5: return !n;
            4'h6: return v;          4'h7: return !v;
            4'h8: return cy && !z;   4'h9: return !cy || z;
            4'hA: return n == v;     4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic t_r7_cond_sweep;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                apply(mk(4'(c), 8'h29, 4'h0), 4'(f));
                chk_bit("R7 cond", exec_o, exp_cond(4'(c), 4'(f)));
            end
        end
    endtask

    task automatic t_r8_gating;
        apply(mk(4'hF, 8'hC0, 4'h0), 4'h0);
        chk_cls("R8 class kept on fail", UND, 6'b0);
        chk_bit("R8 no undef on fail", undef_o, 1'b0);
        chk_bit("R8 exec low", exec_o, 1'b0);
        apply(mk(4'h0, 8'h59, 4'h0), 4'h0);
        chk_cls("R8 sdt kept on fail", SDT, 6'b011001);
        chk_bit("R8 eq fail exec", exec_o, 1'b0);
        apply(mk(4'h0, 8'hE0, 4'h0), 4'b0100);
        chk_bit("R8 undef eq pass", undef_o, 1'b1);
    endtask

    task automatic t_r9_attr_clear;
        apply(32'hE12F_FF1F, 4'h0); chk_cls("R9 bx attr", BX, 6'b0);
        apply(mk(4'hE, 8'hFF, 4'hF), 4'h0); chk_cls("R9 trap attr", TRAP, 6'b0);
        apply(mk(4'hE, 8'hBF, 4'hF), 4'h0); chk_cls("R9 br narrow", BR, 6'b000001);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        instr = '0;
        nzcv  = '0;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_r2_priority();
        t_r3_fallthrough();
        t_r4_memory();
        t_r5_control();
        t_r7_cond_sweep();
        t_r8_gating();
        t_r9_attr_clear();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule